// File: doc/BRIEF.md
# Flash Program/Erase Controller

This block manages a byte-wide non-volatile code array on behalf of firmware. The array is split into sectors, and each sector is split into 64-byte pages. Software works through four byte-wide registers: a command/status register, a data register, and two address registers. Through them it can read a byte, erase at four granularities, and program a page. A page is programmed by loading any subset of a 64-byte page buffer and then committing that subset in one operation.

Every erase and program runs for a fixed time, modelled as `OP_CYCLES` clock cycles. After that wait, the controller walks the affected bytes. Each sector can be locked so that data reads into it are refused. Read-back verification is not offered. Instead, the controller computes a CRC-32 over one sector or over the whole array, and software reads the result back one byte at a time.

By default there are eight sectors of four 64-byte pages each, which gives 2 KB. Setting `PAGES_PER_SECTOR` to 16 gives eight 1 KB sectors, an 8 KB array.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the status, data and both address registers read 0. Every array byte reads 0xFF (erased).
- R2: The register offsets are 0 = command (write) / status (read), 1 = data, 2 = address high, 3 = address low. In the status byte, bit 7 is busy and bit 6 is error; the other bits are 0. Read data is registered and appears on the cycle after the read strobe.
- R3: Busy is set from the cycle after an erase or program command is accepted. It stays set for at least `OP_CYCLES` cycles and until the operation ends. While busy, writes to any register are ignored.
- R4: A data-register write stores the byte into the page-buffer entry selected by address-low bits [5:0] and sets that entry's load flag. Command 0x06 writes only the flagged entries into the page that holds the current address. All flags clear when the commit ends.
- R5: Programming only clears bits: the stored byte becomes old AND new.
- R6: Command 0x02 sets only the addressed byte to 0xFF.
- R7: Command 0x03 sets every byte of the 64-byte page that holds the address to 0xFF, and no byte outside that page.
- R8: Command 0x04 sets every byte of the sector that holds the address to 0xFF, and no byte outside that sector.
- R9: Command 0x05 sets the whole array to 0xFF and unlocks all sectors.
- R10: Command 0x09 locks the sector that holds the address. Command 0x01 reads the addressed byte into the data register. If that byte's sector is locked, the read is refused: the error bit is set and the data register is unchanged.
- R11: Any command code other than 0x00–0x09 and 0x10–0x13 sets the error bit. Command 0x00 clears the error bit.
- R12: Command 0x07 computes a CRC over the sector that holds the address, and 0x08 over the whole array. The CRC is the reflected CRC-32 (polynomial 0xEDB88320), starts from all ones, folds bytes in ascending address order one per clock, and is inverted at the end. Command 0x10+k copies CRC byte k into the data register, where k=0 is the least significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
The hardest condition to reach from the ports is a page-buffer flag that survives a commit. Stale buffer data ANDed onto an unchanged byte leaves no visible trace. To expose it, the bench commits a byte, erases that single byte back to 0xFF, and then commits a different offset only. A surviving flag would rewrite the erased byte. The busy window is handled in a similar way. Address writes and a whole-array erase are issued while a sector erase is still running. The bench then reads back the address registers and a byte in another sector.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [1:0] {OP_READ, OP_ERASE, OP_PROG, OP_CRC} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} st_e;

  localparam logic [7:0] CMD_CLR_ERR = 8'h00;
  localparam logic [7:0] CMD_READ    = 8'h01;
  localparam logic [7:0] CMD_ER_BYTE = 8'h02;
  localparam logic [7:0] CMD_ER_PAGE = 8'h03;
  localparam logic [7:0] CMD_ER_SECT = 8'h04;
  localparam logic [7:0] CMD_ER_ALL  = 8'h05;
  localparam logic [7:0] CMD_PROGRAM = 8'h06;
  localparam logic [7:0] CMD_CRC_SEC = 8'h07;
  localparam logic [7:0] CMD_CRC_ALL = 8'h08;
  localparam logic [7:0] CMD_LOCK    = 8'h09;

  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

  function automatic logic [31:0] crc_fold(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction

  function automatic logic cmd_known(input logic [7:0] c);
    return (c <= CMD_LOCK) || (c[7:2] == 6'h04);
  endfunction

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_page_buf.sv
module flash_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int IW         = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  logic [IW-1:0]         ld_idx,
  input  logic [7:0]            ld_data,
  input  logic                  clr,
  input  logic [IW-1:0]         rd_idx,
  output logic [7:0]            rd_data,
  output logic                  rd_flag,
  output logic [PAGE_BYTES-1:0] flags_o
);
  logic [7:0]            ent_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (ld_en) ent_q[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) flag_q <= '0;
    else if (ld_en) flag_q[ld_idx] <= 1'b1;
  end

  assign rd_data = ent_q[rd_idx];
  assign rd_flag = flag_q[rd_idx];
  assign flags_o = flag_q;
endmodule

// File: rtl/flash_crc32.sv
module flash_crc32
  import flash_pe_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= '1;
    else if (en)     crc_q <= crc_fold(crc_q, din);
  end

  assign crc_o = ~crc_q;
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int SECTORS          = 8,
  parameter int PAGES_PER_SECTOR = 4,
  parameter int PAGE_BYTES       = 64,
  parameter int OP_CYCLES        = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int SECTOR_BYTES = PAGES_PER_SECTOR * PAGE_BYTES;
  localparam int TOTAL        = SECTORS * SECTOR_BYTES;
  localparam int AW           = $clog2(TOTAL);
  localparam int PW           = $clog2(PAGE_BYTES);
  localparam int SW           = $clog2(SECTORS);
  localparam int TW           = $clog2(OP_CYCLES + 1);
  localparam int CW           = TW + 1;

  logic [7:0]         ah_q, al_q, data_q, rdata_q;
  logic               err_q, busy_q;
  logic [SECTORS-1:0] lock_q;
  st_e                st_q;
  op_e                op_q;
  logic [AW-1:0]      base_q;
  logic [AW:0]        len_q, idx_q;
  logic               phase_q, pend_q;
  logic [TW-1:0]      timer_q;

  logic [AW-1:0] addr, page_base, sect_base, walk_addr;
  logic [SW-1:0] sec_idx;
  assign addr      = AW'({ah_q, al_q});
  assign sec_idx   = addr[AW-1 -: SW];
  assign page_base = {addr[AW-1:PW], {PW{1'b0}}};
  assign sect_base = {sec_idx, {(AW-SW){1'b0}}};
  assign walk_addr = base_q + idx_q[AW-1:0];

  // command decode
  logic          cmd_acc, dec_start, dec_timed, dec_crc_init, dec_lock, dec_unlock_all;
  logic          dec_err_set, dec_err_clr, dec_crc_byte;
  op_e           dec_op;
  logic [AW-1:0] dec_base;
  logic [AW:0]   dec_len;
  logic [31:0]   crc_val;

  assign cmd_acc = reg_we && (reg_addr == 2'd0) && !busy_q;

  always_comb begin
    dec_start = 1'b0; dec_timed = 1'b0; dec_crc_init = 1'b0; dec_lock = 1'b0;
    dec_unlock_all = 1'b0; dec_err_set = 1'b0; dec_err_clr = 1'b0; dec_crc_byte = 1'b0;
    dec_op = OP_READ; dec_base = addr; dec_len = (AW+1)'(1);
    if (cmd_acc) begin
      case (reg_wdata)
        CMD_CLR_ERR: dec_err_clr = 1'b1;
        CMD_READ: begin
          if (lock_q[sec_idx]) dec_err_set = 1'b1;
          else dec_start = 1'b1;
        end
        CMD_ER_BYTE: begin dec_start = 1'b1; dec_timed = 1'b1; dec_op = OP_ERASE; end
        CMD_ER_PAGE: begin
          dec_start = 1'b1; dec_timed = 1'b1; dec_op = OP_ERASE;
          dec_base = page_base; dec_len = (AW+1)'(PAGE_BYTES);
        end
        CMD_ER_SECT: begin
          dec_start = 1'b1; dec_timed = 1'b1; dec_op = OP_ERASE;
          dec_base = sect_base; dec_len = (AW+1)'(SECTOR_BYTES);
        end
        CMD_ER_ALL: begin
          dec_start = 1'b1; dec_timed = 1'b1; dec_op = OP_ERASE; dec_unlock_all = 1'b1;
          dec_base = '0; dec_len = (AW+1)'(TOTAL);
        end
        CMD_PROGRAM: begin
          dec_start = 1'b1; dec_timed = 1'b1; dec_op = OP_PROG;
          dec_base = page_base; dec_len = (AW+1)'(PAGE_BYTES);
        end
        CMD_CRC_SEC: begin
          dec_start = 1'b1; dec_op = OP_CRC; dec_crc_init = 1'b1;
          dec_base = sect_base; dec_len = (AW+1)'(SECTOR_BYTES);
        end
        CMD_CRC_ALL: begin
          dec_start = 1'b1; dec_op = OP_CRC; dec_crc_init = 1'b1;
          dec_base = '0; dec_len = (AW+1)'(TOTAL);
        end
        CMD_LOCK: dec_lock = 1'b1;
        8'h10, 8'h11, 8'h12, 8'h13: dec_crc_byte = 1'b1;
        default: dec_err_set = 1'b1;
      endcase
    end
  end

  // datapath to array, buffer, crc
  logic       last, issued_all, mem_we, pb_clr, pb_ld, pb_flag, crc_en;
  logic [7:0] mem_wdata, mem_rdata, pb_data;
  logic [PAGE_BYTES-1:0] pb_flags;

  assign last       = (idx_q == len_q - 1'b1);
  assign issued_all = (idx_q == len_q);
  assign pb_ld      = reg_we && (reg_addr == 2'd1) && !busy_q;
  assign pb_clr     = (st_q == ST_RUN) && (op_q == OP_PROG) && phase_q && last;
  assign crc_en     = (st_q == ST_RUN) && (op_q == OP_CRC) && pend_q;

  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = 8'hFF;
    if (st_q == ST_RUN) begin
      if (op_q == OP_ERASE) mem_we = 1'b1;
      else if (op_q == OP_PROG && phase_q) begin
        mem_we    = pb_flag;
        mem_wdata = mem_rdata & pb_data;
      end
    end
  end

  flash_array #(.DEPTH(TOTAL), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(walk_addr), .wdata(mem_wdata),
    .raddr(walk_addr), .rdata(mem_rdata)
  );

  flash_page_buf #(.PAGE_BYTES(PAGE_BYTES), .IW(PW)) u_pbuf (
    .clk(clk), .rst(rst), .ld_en(pb_ld), .ld_idx(al_q[PW-1:0]), .ld_data(reg_wdata),
    .clr(pb_clr), .rd_idx(idx_q[PW-1:0]), .rd_data(pb_data), .rd_flag(pb_flag),
    .flags_o(pb_flags)
  );

  flash_crc32 u_crc (
    .clk(clk), .rst(rst), .init(dec_crc_init), .en(crc_en), .din(mem_rdata), .crc_o(crc_val)
  );

  // register file and sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      ah_q <= '0; al_q <= '0; data_q <= '0; rdata_q <= '0;
      err_q <= 1'b0; busy_q <= 1'b0; lock_q <= '0;
      st_q <= ST_IDLE; op_q <= OP_READ; base_q <= '0; len_q <= '0; idx_q <= '0;
      phase_q <= 1'b0; pend_q <= 1'b0; timer_q <= '0;
    end else begin
      if (reg_re) begin
        case (reg_addr)
          2'd0:    rdata_q <= {busy_q, err_q, 6'b0};
          2'd1:    rdata_q <= data_q;
          2'd2:    rdata_q <= ah_q;
          default: rdata_q <= al_q;
        endcase
      end
      if (reg_we && !busy_q) begin
        if (reg_addr == 2'd2) ah_q <= reg_wdata;
        if (reg_addr == 2'd3) al_q <= reg_wdata;
      end
      if (dec_err_set) err_q <= 1'b1;
      if (dec_err_clr) err_q <= 1'b0;
      if (dec_lock) lock_q[sec_idx] <= 1'b1;
      if (dec_unlock_all) lock_q <= '0;
      if (dec_crc_byte) data_q <= crc_val[8*reg_wdata[1:0] +: 8];
      if (dec_start) begin
        op_q <= dec_op; base_q <= dec_base; len_q <= dec_len;
        idx_q <= '0; phase_q <= 1'b0; pend_q <= 1'b0; timer_q <= '0;
        busy_q <= 1'b1;
        st_q <= dec_timed ? ST_WAIT : ST_RUN;
      end

      case (st_q)
        ST_WAIT: begin
          timer_q <= timer_q + 1'b1;
          if (timer_q == TW'(OP_CYCLES - 1)) begin
            st_q <= ST_RUN; timer_q <= '0;
          end
        end
        ST_RUN: begin
          case (op_q)
            OP_ERASE: begin
              idx_q <= idx_q + 1'b1;
              if (last) begin st_q <= ST_IDLE; busy_q <= 1'b0; end
            end
            OP_PROG: begin
              phase_q <= ~phase_q;
              if (phase_q) begin
                idx_q <= idx_q + 1'b1;
                if (last) begin st_q <= ST_IDLE; busy_q <= 1'b0; end
              end
            end
            default: begin
              if (!issued_all) idx_q <= idx_q + 1'b1;
              pend_q <= !issued_all;
              if (pend_q && op_q == OP_READ) data_q <= mem_rdata;
              if (issued_all && pend_q) begin st_q <= ST_IDLE; busy_q <= 1'b0; end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  assign reg_rdata = rdata_q;

  // checker state: busy cycles since the last accepted operation
  logic [CW-1:0] chk_cnt;
  logic          chk_timed;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_cnt <= '0; chk_timed <= 1'b0;
    end else if (dec_start) begin
      chk_cnt <= '0; chk_timed <= dec_timed;
    end else if (busy_q && chk_cnt != CW'(OP_CYCLES)) begin
      chk_cnt <= chk_cnt + 1'b1;
    end
  end

  assert_busy_min_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_q) && chk_timed) |-> (chk_cnt >= CW'(OP_CYCLES)));

  assert_busy_ignores_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && reg_we && reg_addr == 2'd2) |=> $stable(ah_q));

  assert_write_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy_q);

  assert_flags_clear_R4: assert property (@(posedge clk) disable iff (rst)
    pb_clr |=> (pb_flags == '0));

  assert_locked_read_refused_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_acc && reg_wdata == CMD_READ && lock_q[sec_idx]) |=> (err_q && $stable(data_q)));

  assert_illegal_sets_err_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_acc && !cmd_known(reg_wdata)) |=> err_q);

endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;
  localparam int OPC   = 16;
  localparam int PAGE  = 64;
  localparam int SECT  = 256;
  localparam int TOTAL = 2048;

  logic       clk = 1'b0, rst = 1'b1, reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [TOTAL];

  always #2 clk = ~clk;

  flash_pe_ctrl #(.SECTORS(8), .PAGES_PER_SECTOR(4), .PAGE_BYTES(PAGE), .OP_CYCLES(OPC)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(2'd2, a[15:8]); wr(2'd3, a[7:0]);
  endtask

  task automatic wait_idle(output int busy_seen);
    logic [7:0] s;
    busy_seen = 0;
    for (int n = 0; n < 5000; n++) begin
      rd(2'd0, s);
      if (!s[7]) break;
      busy_seen++;
    end
    if (s[7]) chk("R3 operation never finished", 32'd1, 32'd0);
  endtask

  task automatic run_cmd(input logic [7:0] c);
    int b;
    wr(2'd0, c); wait_idle(b);
  endtask

  task automatic read_byte(input logic [15:0] a, output logic [7:0] v);
    set_addr(a); run_cmd(8'h01); rd(2'd1, v);
  endtask

  task automatic expect_byte(input string req, input logic [15:0] a);
    logic [7:0] v;
    read_byte(a, v);
    chk(req, {24'd0, v}, {24'd0, model[a]});
  endtask

  task automatic load(input logic [15:0] a, input logic [7:0] d);
    wr(2'd3, a[7:0]); wr(2'd1, d);
  endtask

  task automatic commit(input logic [15:0] a);
    set_addr(a); run_cmd(8'h06);
  endtask

  task automatic erase_model(input int start, input int len);
    for (int i = start; i < start + len; i++) model[i] = 8'hFF;
  endtask

  function automatic logic [31:0] ref_crc(input int start, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = start; i < start + len; i++) begin
      c = c ^ {24'd0, model[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 status after reset", {24'd0, v}, 32'h00);
    rd(2'd1, v); chk("R1 data after reset", {24'd0, v}, 32'h00);
    rd(2'd2, v); chk("R2 addr high after reset", {24'd0, v}, 32'h00);
    rd(2'd3, v); chk("R2 addr low after reset", {24'd0, v}, 32'h00);
    expect_byte("R1 erased array byte", 16'h0123);
  endtask

  task automatic t_program;
    logic [7:0] v;
    int b;
    load(16'h00C0, 8'hA5); load(16'h00C5, 8'h5A); load(16'h00FF, 8'h3C);
    set_addr(16'h00C0); wr(2'd0, 8'h06); wait_idle(b);
    total++;
    if (b < OPC) begin bad++; $display("FAIL R3 busy window actual=%0d expected>=%0d", b, OPC); end
    model[16'h00C0] = 8'hA5; model[16'h00C5] = 8'h5A; model[16'h00FF] = 8'h3C;
    expect_byte("R4 flagged byte 0", 16'h00C0);
    expect_byte("R4 flagged byte 5", 16'h00C5);
    expect_byte("R4 flagged byte 63", 16'h00FF);
    expect_byte("R4 unflagged byte", 16'h00C1);
    set_addr(16'h00FF); run_cmd(8'h02); model[16'h00FF] = 8'hFF;
    expect_byte("R6 erased byte", 16'h00FF);
    expect_byte("R6 neighbour untouched", 16'h00C5);
    load(16'h00C0, 8'h0F); commit(16'h00C0); model[16'h00C0] = 8'h05;
    expect_byte("R5 AND with old value", 16'h00C0);
    expect_byte("R4 flags cleared after commit", 16'h00FF);
    rd(2'd0, v); chk("R4 no error after commits", {24'd0, v}, 32'h00);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v;
    int b;
    load(16'h0105, 8'h77); commit(16'h0100); model[16'h0105] = 8'h77;
    set_addr(16'h0000);
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h07); wr(2'd3, 8'h33); wr(2'd0, 8'h05);
    wait_idle(b);
    erase_model(0, SECT);
    rd(2'd2, v); chk("R3 addr high write ignored while busy", {24'd0, v}, 32'h00);
    rd(2'd3, v); chk("R3 addr low write ignored while busy", {24'd0, v}, 32'h00);
    expect_byte("R3 erase-all ignored while busy", 16'h0105);
    expect_byte("R8 sector erased", 16'h00C0);
    expect_byte("R8 sector erased", 16'h00C5);
  endtask

  task automatic t_erase_page;
    load(16'h0140, 8'h11); load(16'h017F, 8'h22); commit(16'h0140);
    load(16'h0180, 8'h33); commit(16'h0180);
    model[16'h0140] = 8'h11; model[16'h017F] = 8'h22; model[16'h0180] = 8'h33;
    expect_byte("R4 two bytes one commit", 16'h017F);
    set_addr(16'h0150); run_cmd(8'h03); erase_model(16'h0140, PAGE);
    expect_byte("R7 page first byte", 16'h0140);
    expect_byte("R7 page last byte", 16'h017F);
    expect_byte("R7 next page kept", 16'h0180);
    expect_byte("R7 previous page kept", 16'h0105);
  endtask

  task automatic t_security;
    logic [7:0] v;
    load(16'h0210, 8'h44); commit(16'h0200); model[16'h0210] = 8'h44;
    expect_byte("R10 unlocked read", 16'h0105);
    set_addr(16'h0200); wr(2'd0, 8'h09);
    set_addr(16'h0210); wr(2'd0, 8'h01);
    rd(2'd0, v); chk("R10 locked read sets error", {24'd0, v}, 32'h40);
    rd(2'd1, v); chk("R10 locked read leaves data", {24'd0, v}, 32'h77);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R11 clear error", {24'd0, v}, 32'h00);
    expect_byte("R10 other sector readable", 16'h0310);
  endtask

  task automatic t_illegal;
    logic [7:0] v;
    wr(2'd0, 8'h7E);
    rd(2'd0, v); chk("R11 illegal code sets error", {24'd0, v}, 32'h40);
    wr(2'd0, 8'h0A);
    rd(2'd0, v); chk("R11 code 0x0A illegal", {24'd0, v}, 32'h40);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R11 error cleared", {24'd0, v}, 32'h00);
  endtask

  task automatic get_crc(output logic [31:0] c);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 8'h10 + 8'(k)); rd(2'd1, v); c[8*k +: 8] = v;
    end
  endtask

  task automatic t_crc;
    logic [31:0] c;
    set_addr(16'h0100); run_cmd(8'h07); get_crc(c);
    chk("R12 sector CRC", c, ref_crc(16'h0100, SECT));
    set_addr(16'h0000); run_cmd(8'h07); get_crc(c);
    chk("R12 erased sector CRC", c, ref_crc(0, SECT));
    run_cmd(8'h08); get_crc(c);
    chk("R12 whole-array CRC", c, ref_crc(0, TOTAL));
  endtask

  task automatic t_erase_all;
    logic [7:0] v;
    run_cmd(8'h05); erase_model(0, TOTAL);
    expect_byte("R9 whole array erased", 16'h0105);
    expect_byte("R9 lock removed, byte erased", 16'h0210);
    rd(2'd0, v); chk("R9 lock removed, no error", {24'd0, v}, 32'h00);
    expect_byte("R9 top byte erased", 16'h07FF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_busy_ignore();
    t_erase_page();
    t_security();
    t_illegal();
    t_crc();
    t_erase_all();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule